// File: doc/BRIEF.md
# Dual-Edge Interrupt Status Controller

This block gathers seven status conditions from a voltage regulator and raises an interrupt to the host whenever any of them changes level. The seven lines are thermal shutdown, thermal warning, thermal pre-warning, undervoltage lockout, converter current beyond its limit, short-circuit protection and power good. Each line is brought into the clock domain through a synchronizer and then compared with its previous level. Any change, whether upward or downward, leaves a sticky flag behind.

The host sees three registers through a simple strobe-and-address read port. The first holds the sticky event flags and empties itself when it is read. The second shows the present synchronized level of every line. The third is a per-source mask, which also has a write path. The active-low interrupt output stays low while any unmasked flag is set.

Top module: `irq_status_ctrl`

## Requirements
- R1: After a synchronous active-high reset, all event flags and all mask bits are 0, `irq_n` is 1 and `rd_data` is 0.
- R2: Each status input passes through two flip-flops. A level driven before clock edge k is returned by a sense read whose strobe is sampled at edge k+2, and not by one sampled at edge k+1.
- R3: A 0-to-1 change of status bit i sets event flag bit i. Bit order: 0 thermal shutdown, 1 thermal warning, 2 thermal pre-warning, 3 undervoltage, 4 current limit, 5 short circuit, 6 power good. The first high level seen after reset also counts as a rising change.
- R4: A 1-to-0 change of status bit i also sets event flag bit i.
- R5: An event flag stays at 1, whatever the input does, until a read of the event register.
- R6: A read strobe with `addr` = 0 returns the event flags as they were before that edge, zero-extended to `DW` bits, and clears every flag in the same edge.
- R7: A change detected in the same edge as a clearing read keeps its flag set. The following read of the event register returns that flag.
- R8: A read with `addr` = 1 returns the synchronized live levels. Reading them neither sets nor clears any event flag.
- R9: `irq_n` is registered. It is 0 one cycle after any event flag whose mask bit is 0 is set, and 1 one cycle after no such flag remains.
- R10: A write strobe with `addr` = 2 loads the mask, where 1 means masked. A read with `addr` = 2 returns it. Masked sources still set their event flags.
- R11: A read with `addr` = 3 returns 0 and leaves the event flags unchanged. `rd_data` holds its value in cycles without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| status_in | input | NSRC | Raw status levels, one per source |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe (only the mask is writable) |
| addr | input | 2 | Register select: 0 events, 1 sense, 2 mask |
| wr_data | input | NSRC | Mask value to write |
| rd_data | output | DW | Registered read data |
| irq_n | output | 1 | Interrupt request, active low, registered |

## Verification
Two functions can fall in the same clock edge: a change detected on a status line, and the clearing read of the event register. If the clear were allowed to win, the event would be lost. The bench provokes this on purpose by changing an input exactly two cycles before it issues an event read, so that detection lands on the read's edge. It then requires that the clearing read returns the older flags without the new bit, and that the next read returns the new bit. The random phase also produces many such collisions, and each one is judged against the bench's cycle model, in which the OR-in of new events follows the clear.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_EVT   = 2'd0,
    REG_SENSE = 2'd1,
    REG_MASK  = 2'd2,
    REG_NONE  = 2'd3
  } reg_sel_e;

  typedef enum int {
    SRC_TSHUT  = 0,
    SRC_TWARN  = 1,
    SRC_TPRE   = 2,
    SRC_UVLO   = 3,
    SRC_ILIM   = 4,
    SRC_SHORT  = 5,
    SRC_PGOOD  = 6,
    SRC_COUNT  = 7
  } src_idx_e;
endpackage

// File: rtl/irq_sync_edge.sv
`timescale 1ns/1ps
module irq_sync_edge #(
  parameter int NSRC   = 7,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] din,
  output logic [NSRC-1:0] level,
  output logic [NSRC-1:0] evt
);
  localparam int TOP = STAGES - 1;

  logic [NSRC-1:0] prev_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[STAGES-2:0], din[i]};
    end
    assign level[i] = chain_q[TOP];
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= level;
  end

  assign evt = level ^ prev_q;
endmodule

// File: rtl/irq_evt_reg.sv
`timescale 1ns/1ps
module irq_evt_reg #(
  parameter int NSRC = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] evt,
  input  logic            clr,
  output logic [NSRC-1:0] flags
);
  logic [NSRC-1:0] kept;

  always_comb kept = clr ? '0 : flags;

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= kept | evt;
  end
endmodule

// File: rtl/irq_reg_if.sv
`timescale 1ns/1ps
module irq_reg_if
  import irq_pkg::*;
#(
  parameter int NSRC = 7,
  parameter int DW   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NSRC-1:0]   wr_data,
  input  logic [NSRC-1:0]   flags,
  input  logic [NSRC-1:0]   level,
  output logic [NSRC-1:0]   mask,
  output logic              clr,
  output logic [DW-1:0]     rd_data
);
  logic [DW-1:0] rd_mux;

  always_comb begin
    unique case (reg_sel_e'(addr))
      REG_EVT:   rd_mux = DW'(flags);
      REG_SENSE: rd_mux = DW'(level);
      REG_MASK:  rd_mux = DW'(mask);
      default:   rd_mux = '0;
    endcase
  end

  assign clr = rd_en && (reg_sel_e'(addr) == REG_EVT);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask    <= '0;
      rd_data <= '0;
    end else begin
      if (wr_en && reg_sel_e'(addr) == REG_MASK) mask <= wr_data;
      if (rd_en) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/irq_status_ctrl.sv
`timescale 1ns/1ps
module irq_status_ctrl
  import irq_pkg::*;
#(
  parameter int NSRC   = 7,
  parameter int DW     = 8,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   status_in,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NSRC-1:0]   wr_data,
  output logic [DW-1:0]     rd_data,
  output logic              irq_n
);
  logic [NSRC-1:0] lvl_v;
  logic [NSRC-1:0] evt_v;
  logic [NSRC-1:0] ack_q;
  logic [NSRC-1:0] mask_q;
  logic            clr_s;

  irq_sync_edge #(.NSRC(NSRC), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(status_in), .level(lvl_v), .evt(evt_v)
  );

  irq_evt_reg #(.NSRC(NSRC)) u_evt (
    .clk(clk), .rst(rst), .evt(evt_v), .clr(clr_s), .flags(ack_q)
  );

  irq_reg_if #(.NSRC(NSRC), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .flags(ack_q), .level(lvl_v), .mask(mask_q),
    .clr(clr_s), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~|(ack_q & ~mask_q);
  end
endmodule

// File: rtl/irq_status_chk.sv
`timescale 1ns/1ps
module irq_status_chk
  import irq_pkg::*;
#(
  parameter int NSRC = 7,
  parameter int DW   = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [NSRC-1:0]   evt_v,
  input logic [NSRC-1:0]   ack,
  input logic [NSRC-1:0]   mask,
  input logic [NSRC-1:0]   level,
  input logic              irq_n,
  input logic [DW-1:0]     rd_data
);
  logic evt_rd, sense_rd;
  assign evt_rd   = rd_en && addr == REG_EVT;
  assign sense_rd = rd_en && addr == REG_SENSE;

  assert_evt_sets_R3: assert property (@(posedge clk) disable iff (rst)
    (|evt_v) |=> ((ack & $past(evt_v)) == $past(evt_v)));

  assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    !evt_rd |=> ((ack & $past(ack)) == $past(ack)));

  assert_read_returns_R6: assert property (@(posedge clk) disable iff (rst)
    evt_rd |=> (rd_data == DW'($past(ack))));

  assert_collide_kept_R7: assert property (@(posedge clk) disable iff (rst)
    evt_rd |=> (ack == $past(evt_v)));

  assert_sense_read_R8: assert property (@(posedge clk) disable iff (rst)
    sense_rd |=> (rd_data == DW'($past(level))));

  assert_irq_level_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_n == ~|($past(ack) & ~$past(mask))));
endmodule

bind irq_status_ctrl irq_status_chk #(.NSRC(NSRC), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .evt_v(evt_v),
  .ack(ack_q), .mask(mask_q), .level(lvl_v), .irq_n(irq_n), .rd_data(rd_data)
);

// File: tb/irq_status_ctrl_tb.sv
`timescale 1ns/1ps
module irq_status_ctrl_tb;
  localparam int NSRC = 7;
  localparam int DW   = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] st = '0;
  logic            rd_en = 1'b0;
  logic            wr_en = 1'b0;
  logic [1:0]      addr = '0;
  logic [NSRC-1:0] wdata = '0;
  logic [DW-1:0]   rd_data;
  logic            irq_n;

  irq_status_ctrl #(.NSRC(NSRC), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .status_in(st), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wr_data(wdata), .rd_data(rd_data), .irq_n(irq_n)
  );

  always #5 clk = ~clk;

  logic [NSRC-1:0] m_ff1 = '0, m_sense = '0, m_prev = '0, m_ack = '0, m_mask = '0;
  logic [DW-1:0]   m_rd = '0;
  logic            m_irqn = 1'b1;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic logic [DW-1:0] exp_rd(input logic [1:0] a, input logic [NSRC-1:0] ack,
                                           input logic [NSRC-1:0] sense, input logic [NSRC-1:0] mask);
    case (a)
      2'd0:    return DW'(ack);
      2'd1:    return DW'(sense);
      2'd2:    return DW'(mask);
      default: return '0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic [NSRC-1:0] s, input bit r,
                      input logic [1:0] a, input bit w, input logic [NSRC-1:0] wd);
    logic [NSRC-1:0] evt;
    st = s; rd_en = r; addr = a; wr_en = w; wdata = wd;
    @(posedge clk);
    evt = m_sense ^ m_prev;
    if (r) m_rd = exp_rd(a, m_ack, m_sense, m_mask);
    m_irqn = ~|(m_ack & ~m_mask);
    m_ack = ((r && a == 2'd0) ? '0 : m_ack) | evt;
    if (w && a == 2'd2) m_mask = wd;
    m_prev = m_sense; m_sense = m_ff1; m_ff1 = s;
    @(negedge clk);
    check(tag, 32'(rd_data), 32'(m_rd));
    check("R9 irq_n level", 32'(irq_n), 32'(m_irqn));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 irq_n after reset", 32'(irq_n), 32'd1);
    check("R1 rd_data after reset", 32'(rd_data), 32'd0);
    step("R1 events zero", '0, 1, 2'd0, 0, '0);
    step("R1 mask zero", '0, 1, 2'd2, 0, '0);

    // R2: latency of the sense path
    step("R2 idle", 7'h01, 0, 2'd0, 0, '0);
    step("R2 sense one edge later still old", 7'h01, 1, 2'd1, 0, '0);
    check("R2 sense not yet visible", 32'(rd_data), 32'd0);
    step("R2 sense two edges later new", 7'h01, 1, 2'd1, 0, '0);
    check("R2 sense visible", 32'(rd_data), 32'h01);
    step("R3 idle", 7'h01, 0, 2'd0, 0, '0);
    check("R9 irq asserted for thermal shutdown", 32'(irq_n), 32'd0);
    step("R3 rising edge latched", 7'h01, 1, 2'd0, 0, '0);
    check("R3 bit0 set", 32'(rd_data), 32'h01);

    // R4 + R5: falling edge on power good, flag sticks after the line returns
    step("R4 set pgood", 7'h41, 0, 2'd0, 0, '0);
    repeat (4) step("R4 idle", 7'h41, 0, 2'd0, 0, '0);
    step("R4 clear", 7'h41, 1, 2'd0, 0, '0);
    step("R4 fall pgood", 7'h01, 0, 2'd0, 0, '0);
    step("R4 rise again", 7'h41, 0, 2'd0, 0, '0);
    repeat (4) step("R5 hold", 7'h41, 0, 2'd0, 0, '0);
    step("R5 sticky after return", 7'h41, 1, 2'd0, 0, '0);
    check("R5 pgood flag kept", 32'(rd_data), 32'h40);
    step("R6 cleared", 7'h41, 1, 2'd0, 0, '0);
    check("R6 second read empty", 32'(rd_data), 32'h00);

    // R7: change detected on the edge of a clearing read
    step("R7 change", 7'h49, 0, 2'd0, 0, '0);
    step("R7 sync", 7'h49, 0, 2'd0, 0, '0);
    step("R7 read on detect edge", 7'h49, 1, 2'd0, 0, '0);
    check("R7 clearing read excludes new bit", 32'(rd_data), 32'h00);
    step("R7 bit survived", 7'h49, 1, 2'd0, 0, '0);
    check("R7 bit3 returned", 32'(rd_data), 32'h08);

    // R8: sense read leaves flags alone; R11: address 3
    step("R8 change", 7'h48, 0, 2'd0, 0, '0);
    repeat (3) step("R8 sense read", 7'h48, 1, 2'd1, 0, '0);
    check("R8 live level", 32'(rd_data), 32'h48);
    step("R11 unused address", 7'h48, 1, 2'd3, 0, '0);
    check("R11 reads zero", 32'(rd_data), 32'h00);
    step("R11 hold without strobe", 7'h48, 0, 2'd0, 0, '0);
    check("R11 rd_data held", 32'(rd_data), 32'h00);
    step("R11 flags untouched", 7'h48, 1, 2'd0, 0, '0);
    check("R11 bit0 still flagged", 32'(rd_data), 32'h01);

    // R10: masking
    step("R10 write mask", 7'h48, 0, 2'd2, 1, 7'h7F);
    step("R10 mask readback", 7'h48, 1, 2'd2, 0, '0);
    check("R10 mask value", 32'(rd_data), 32'h7F);
    step("R10 masked change", 7'h68, 0, 2'd0, 0, '0);
    repeat (4) step("R10 idle", 7'h68, 0, 2'd0, 0, '0);
    check("R10 masked irq stays high", 32'(irq_n), 32'd1);
    step("R10 masked flag still set", 7'h68, 1, 2'd0, 0, '0);
    check("R10 bit5 flagged", 32'(rd_data), 32'h20);
    step("R10 unmask", 7'h68, 0, 2'd2, 1, 7'h00);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [NSRC-1:0] s;
      logic [1:0] a;
      bit r, w;
      string tag;
      s = st;
      for (int b = 0; b < NSRC; b++) if ($urandom % 12 == 0) s[b] = ~s[b];
      r = ($urandom % 3 == 0);
      w = ($urandom % 40 == 0);
      a = 2'($urandom % 4);
      case (a)
        2'd0:    tag = "R6 random event read";
        2'd1:    tag = "R8 random sense read";
        2'd2:    tag = "R10 random mask read";
        default: tag = "R11 random unused read";
      endcase
      step(tag, s, r, a, w, 7'($urandom));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule